// File: doc/BRIEF.md
# RAM Bank Address Decoder

This block turns a bus address inside a programmable RAM window into a select line for one memory bank and an address relative to that bank's start. The window has a 12-bit base and a 12-bit mask over the top address bits. Inside the window there can be up to five static-RAM banks and two synchronous-DRAM banks. Two configuration bits choose how the window is split. With static RAM only, up to four equal banks sit from the window start and an optional fifth bank fills the upper half. With both memory kinds, up to four static banks sit in the lower half and two DRAM banks start at the upper half. With DRAM only, the two DRAM banks start at the window bottom and the upper half is left empty.

The bank layout is recomputed from the configuration inputs in every cycle. A memory controller can therefore rewrite its size and mode fields at any time, and the next decode uses the new map. The decode is combinational and goes into one output register stage, so a result appears one clock after its inputs.

Top module: `ram_bank_decoder`

## Requirements
- R1: An address is inside the window when `(bus_addr[31:20] ^ win_base) & win_mask` is zero. The window size in MB is 4096 minus `win_mask`, its halfway point is half of that size, and an address outside the window gives no hit.
- R2: A static bank is 8 KB shifted left by `sram_size_code` (0 = 8 KB, 15 = 256 MB). Static bank i (i = 0..3) starts at i times that size from the window start.
- R3: When `sdram_en` is 0 only static banks are decoded and `sram_dis` has no effect. Static bank 4 then covers the whole upper half of the window.
- R4: When `sdram_en` is 1 and `sram_dis` is 0, DRAM bank j (j = 0,1) starts at the halfway point plus j times the DRAM bank size. The DRAM bank size is 4 MB shifted left by `sdram_size_code` (0 = 4 MB, 7 = 512 MB). Static bank 4 is never selected in this mode.
- R5: When `sdram_en` and `sram_dis` are both 1, DRAM bank j starts at j times the DRAM bank size from the window start, no static bank is selected, and an address in the upper half gives no hit.
- R6: Only static banks below `sram_count` are populated. Values above 5 act as 5. An address past the last populated lower bank gives no hit, and static bank 4 needs a count of 5.
- R7: Where bank ranges overlap, the lowest-numbered static bank wins, and any static bank wins over a DRAM bank.
- R8: `bank_sel` is one-hot or zero. Bits 0..4 are static banks 0..4 and bits 5..6 are DRAM banks 0..1. `hit` is set when any bit is set, `is_sdram` is set when bit 5 or 6 is set, and `local_addr` is the window offset minus the selected bank's start (zero on no hit).
- R9: All outputs are registered one clock after their inputs. A synchronous active-low reset clears them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 32 | Address to decode |
| win_base | input | 12 | RAM window base, address bits 31:20 |
| win_mask | input | 12 | RAM window mask, address bits 31:20 |
| sdram_en | input | 1 | Enables the DRAM banks |
| sram_dis | input | 1 | Removes the static banks when DRAM is enabled |
| sram_size_code | input | 4 | Static bank size code |
| sdram_size_code | input | 3 | DRAM bank size code |
| sram_count | input | 3 | Number of populated static banks |
| bank_sel | output | 7 | One-hot bank select |
| hit | output | 1 | Address maps to a bank |
| is_sdram | output | 1 | Selected bank is DRAM |
| local_addr | output | 32 | Offset within the selected bank |

## Verification
The decode is tried in all three partitionings, with addresses at the start, middle and last word of banks and just past the last populated bank. These cases separate the base arithmetic from the range limits. Addresses at and beyond both window edges, and windows of 256 MB, 1 GB and 2 GB, test the mask-derived size and halfway point apart from the bank sizes. Bank counts of 2, 4, 5 and 7, an overlap where 256 MB static banks cover the DRAM half, and mode bit pairs where the disable bit must have no effect separate the count clamp, the priority order and the mode logic. Reset in mid-run and a check of the output before and after the capturing edge confirm the single register stage.

// File: rtl/ramdec_pkg.sv
// Shared types and constants for the RAM bank decoder.
// Assumes byte addresses and a 12-bit window field over the top address bits.
package ramdec_pkg;

    // Partitioning of the RAM window chosen by the two mode bits.
    typedef enum logic [1:0] {
        LAYOUT_SRAM  = 2'd0,
        LAYOUT_MIXED = 2'd1,
        LAYOUT_SDRAM = 2'd2
    } layout_e;

    localparam int SRAM_MIN_LOG2  = 13;  // 8 KB smallest static bank
    localparam int SDRAM_MIN_LOG2 = 22;  // 4 MB smallest DRAM bank

    // Maps the enable and disable bits to a partitioning; disable counts only when DRAM is on.
    function automatic layout_e pick_layout(input logic dram_on, input logic static_off);
        if (!dram_on)
            return LAYOUT_SRAM;
        else if (static_off)
            return LAYOUT_SDRAM;
        else
            return LAYOUT_MIXED;
    endfunction

endpackage

// File: rtl/ramdec_window.sv
// Window match and geometry.
// Decides whether the address falls in the masked window and gives the
// offset from the window start, the window size and its halfway point.
// Assumes the mask is a run of ones from its top bit down.
module ramdec_window #(
    parameter int ADDR_W = 32,
    parameter int WIN_W  = 12,
    localparam int OFF_W = ADDR_W + 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIN_W-1:0]  base,
    input  logic [WIN_W-1:0]  mask,
    output logic              in_win,
    output logic [OFF_W-1:0]  offset,
    output logic [OFF_W-1:0]  size,
    output logic [OFF_W-1:0]  half
);
    localparam int SHIFT = ADDR_W - WIN_W;

    logic [WIN_W:0] size_units;

    // Compare the masked top bits and work out the window geometry.
    always_comb begin
        in_win     = (((addr[ADDR_W-1 -: WIN_W]) ^ base) & mask) == '0;
        size_units = {1'b1, {WIN_W{1'b0}}} - {1'b0, mask};
        size       = {size_units, {SHIFT{1'b0}}};
        half       = size >> 1;
        offset     = {1'b0, addr & ~{mask, {SHIFT{1'b0}}}};
    end

endmodule

// File: rtl/ramdec_range.sv
// One bank range comparator.
// Reports a match when the window offset lies in [start, start + span)
// and the slot is enabled, and gives the offset relative to the start.
module ramdec_range #(
    parameter int ADDR_W = 32,
    localparam int OFF_W = ADDR_W + 1
) (
    input  logic              enable,
    input  logic [OFF_W-1:0]  offset,
    input  logic [OFF_W-1:0]  start,
    input  logic [OFF_W-1:0]  span,
    output logic              match,
    output logic [ADDR_W-1:0] rel
);
    logic [OFF_W:0]   limit;
    logic [OFF_W-1:0] diff;

    // Range test with one extra bit so the upper limit never wraps.
    always_comb begin
        limit = {1'b0, start} + {1'b0, span};
        diff  = offset - start;
        match = enable && (offset >= start) && ({1'b0, offset} < limit);
        rel   = diff[ADDR_W-1:0];
    end

endmodule

// File: rtl/ramdec_pick.sv
// First-match priority selector.
// Slot 0 has the highest priority. Gives a one-hot select and the
// relative address of the winning slot, or zero when nothing matches.
module ramdec_pick #(
    parameter int N  = 7,
    parameter int LW = 32
) (
    input  logic [N-1:0]  match,
    input  logic [LW-1:0] rel [N],
    output logic [N-1:0]  sel,
    output logic [LW-1:0] rel_out
);
    // Walk from slot 0 upward and keep the first match.
    always_comb begin
        logic found;
        found   = 1'b0;
        sel     = '0;
        rel_out = '0;
        for (int k = 0; k < N; k++) begin
            if (match[k] && !found) begin
                found   = 1'b1;
                sel[k]  = 1'b1;
                rel_out = rel[k];
            end
        end
    end

endmodule

// File: rtl/ram_bank_decoder.sv
// RAM bank decoder top.
// Builds the start, span and enable of every bank slot from the mode bits,
// size codes and static bank count. It checks all slots in parallel, picks
// the first match and registers the result. Slots 0..SRAM_SLOTS-2 are the
// lower static banks, slot SRAM_SLOTS-1 is the upper-half static bank, and
// the DRAM slots follow. Overlap beyond first-match priority is not resolved.
module ram_bank_decoder #(
    parameter int ADDR_W      = 32,
    parameter int WIN_W       = 12,
    parameter int SRAM_SLOTS  = 5,
    parameter int SDRAM_SLOTS = 2,
    parameter int CNT_W       = 3,
    parameter int SSZ_W       = 4,
    parameter int DSZ_W       = 3,
    localparam int NSLOT      = SRAM_SLOTS + SDRAM_SLOTS,
    localparam int OFF_W      = ADDR_W + 1,
    localparam int LOW_SLOTS  = SRAM_SLOTS - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIN_W-1:0]  win_base,
    input  logic [WIN_W-1:0]  win_mask,
    input  logic              sdram_en,
    input  logic              sram_dis,
    input  logic [SSZ_W-1:0]  sram_size_code,
    input  logic [DSZ_W-1:0]  sdram_size_code,
    input  logic [CNT_W-1:0]  sram_count,
    output logic [NSLOT-1:0]  bank_sel,
    output logic              hit,
    output logic              is_sdram,
    output logic [ADDR_W-1:0] local_addr
);
    import ramdec_pkg::*;

    localparam logic [OFF_W-1:0] ONE = OFF_W'(1);

    logic              in_win;
    logic [OFF_W-1:0]  offset, size, half;
    layout_e           layout;
    logic [CNT_W-1:0]  count_eff;
    logic [OFF_W-1:0]  sram_span, sdram_span, sdram_origin;

    logic [OFF_W-1:0]  slot_start [NSLOT];
    logic [OFF_W-1:0]  slot_span  [NSLOT];
    logic [NSLOT-1:0]  slot_en;
    logic [NSLOT-1:0]  slot_match;
    logic [ADDR_W-1:0] slot_rel   [NSLOT];

    logic [NSLOT-1:0]  sel_next;
    logic [ADDR_W-1:0] rel_next;

    ramdec_window #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_window (
        .addr   (bus_addr),
        .base   (win_base),
        .mask   (win_mask),
        .in_win (in_win),
        .offset (offset),
        .size   (size),
        .half   (half)
    );

    // Mode, clamped bank count and bank sizes from the configuration inputs.
    always_comb begin
        layout       = pick_layout(sdram_en, sram_dis);
        count_eff    = (sram_count > CNT_W'(SRAM_SLOTS)) ? CNT_W'(SRAM_SLOTS) : sram_count;
        sram_span    = ONE << (SRAM_MIN_LOG2 + int'(sram_size_code));
        sdram_span   = ONE << (SDRAM_MIN_LOG2 + int'(sdram_size_code));
        sdram_origin = (layout == LAYOUT_SDRAM) ? '0 : half;
    end

    // Lower static banks sit back to back from the window start.
    for (genvar i = 0; i < LOW_SLOTS; i++) begin : g_low_sram
        always_comb begin
            slot_start[i] = OFF_W'(i) * sram_span;
            slot_span[i]  = sram_span;
            slot_en[i]    = in_win && (layout != LAYOUT_SDRAM)
                            && (count_eff > CNT_W'(i));
        end
    end

    // The last static bank takes the whole upper half, only in the static-only layout.
    always_comb begin
        slot_start[LOW_SLOTS] = half;
        slot_span[LOW_SLOTS]  = size - half;
        slot_en[LOW_SLOTS]    = in_win && (layout == LAYOUT_SRAM)
                                && (count_eff == CNT_W'(SRAM_SLOTS));
    end

    // DRAM banks follow each other from the half or the bottom, by layout.
    for (genvar j = 0; j < SDRAM_SLOTS; j++) begin : g_sdram
        always_comb begin
            slot_start[SRAM_SLOTS+j] = sdram_origin + OFF_W'(j) * sdram_span;
            slot_span[SRAM_SLOTS+j]  = sdram_span;
            slot_en[SRAM_SLOTS+j]    = in_win && (layout != LAYOUT_SRAM);
        end
    end

    // One comparator per slot.
    for (genvar s = 0; s < NSLOT; s++) begin : g_range
        ramdec_range #(.ADDR_W(ADDR_W)) u_range (
            .enable (slot_en[s]),
            .offset (offset),
            .start  (slot_start[s]),
            .span   (slot_span[s]),
            .match  (slot_match[s]),
            .rel    (slot_rel[s])
        );
    end

    ramdec_pick #(.N(NSLOT), .LW(ADDR_W)) u_pick (
        .match   (slot_match),
        .rel     (slot_rel),
        .sel     (sel_next),
        .rel_out (rel_next)
    );

    // Output register stage with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_sel   <= '0;
            hit        <= 1'b0;
            is_sdram   <= 1'b0;
            local_addr <= '0;
        end else begin
            bank_sel   <= sel_next;
            hit        <= |sel_next;
            is_sdram   <= |sel_next[NSLOT-1:SRAM_SLOTS];
            local_addr <= rel_next;
        end
    end

endmodule

// File: rtl/ram_bank_decoder_checker.sv
// Property checker for the RAM bank decoder, bound to every instance of it.
// Relates the registered outputs to the inputs of the previous cycle.
module ram_bank_decoder_checker #(
    parameter int ADDR_W      = 32,
    parameter int WIN_W       = 12,
    parameter int SRAM_SLOTS  = 5,
    parameter int SDRAM_SLOTS = 2,
    parameter int CNT_W       = 3,
    localparam int NSLOT      = SRAM_SLOTS + SDRAM_SLOTS
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WIN_W-1:0]  win_base,
    input logic [WIN_W-1:0]  win_mask,
    input logic              sdram_en,
    input logic              sram_dis,
    input logic [CNT_W-1:0]  sram_count,
    input logic [NSLOT-1:0]  bank_sel,
    input logic              hit,
    input logic              is_sdram
);
    // R8: at most one bank is selected
    assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_sel));

    // R8: a DRAM result is always a hit
    assert_sdram_is_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_sdram |-> hit);

    // R1: an address outside the window never hits
    assert_outside_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(bus_addr[ADDR_W-1 -: WIN_W]) ^ $past(win_base)) & $past(win_mask)) != '0)
        |-> !hit);

    // R3: static-only layout never yields a DRAM bank
    assert_static_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!sdram_en) |-> !is_sdram);

    // R5: DRAM-only layout never yields a static bank
    assert_dram_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sdram_en && sram_dis) |-> (bank_sel[SRAM_SLOTS-1:0] == '0));

    // R4: the upper-half static bank is absent while DRAM is on
    assert_no_upper_static_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sdram_en) |-> !bank_sel[SRAM_SLOTS-1]);

    // R6: the upper-half static bank needs the full count
    assert_upper_needs_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sram_count) < CNT_W'(SRAM_SLOTS)) |-> !bank_sel[SRAM_SLOTS-1]);

endmodule

bind ram_bank_decoder ram_bank_decoder_checker #(
    .ADDR_W(ADDR_W), .WIN_W(WIN_W), .SRAM_SLOTS(SRAM_SLOTS),
    .SDRAM_SLOTS(SDRAM_SLOTS), .CNT_W(CNT_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .win_base   (win_base),
    .win_mask   (win_mask),
    .sdram_en   (sdram_en),
    .sram_dis   (sram_dis),
    .sram_count (sram_count),
    .bank_sel   (bank_sel),
    .hit        (hit),
    .is_sdram   (is_sdram)
);

// File: tb/ram_bank_decoder_bench.sv
`timescale 1ns/1ps
// Testbench for the RAM bank decoder: a vector table, then directed reset and latency tests.
module ram_bank_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [11:0] win_base = '0;
    logic [11:0] win_mask = '0;
    logic        sdram_en = 1'b0;
    logic        sram_dis = 1'b0;
    logic [3:0]  sram_size_code = '0;
    logic [2:0]  sdram_size_code = '0;
    logic [2:0]  sram_count = '0;
    logic [6:0]  bank_sel;
    logic        hit;
    logic        is_sdram;
    logic [31:0] local_addr;

    int checks = 0;
    int errors = 0;

    ram_bank_decoder u_ram_bank_decoder (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_addr        (bus_addr),
        .win_base        (win_base),
        .win_mask        (win_mask),
        .sdram_en        (sdram_en),
        .sram_dis        (sram_dis),
        .sram_size_code  (sram_size_code),
        .sdram_size_code (sdram_size_code),
        .sram_count      (sram_count),
        .bank_sel        (bank_sel),
        .hit             (hit),
        .is_sdram        (is_sdram),
        .local_addr      (local_addr)
    );

    always #4 clk = ~clk;  // 125 MHz

    typedef struct packed {
        logic [11:0] base;
        logic [11:0] mask;
        logic        se;
        logic        si;
        logic [3:0]  ssz;
        logic [2:0]  dsz;
        logic [2:0]  cnt;
        logic [31:0] addr;
        logic [6:0]  sel;
        logic [31:0] loc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{12'h400, 12'hC00, 1'b0, 1'b0, 4'hE, 3'd0, 3'd4, 32'h4000_0010, 7'h01, 32'h0000_0010, 4'd2}, // R2
        '{12'h400, 12'hC00, 1'b0, 1'b0, 4'hE, 3'd0, 3'd4, 32'h4800_0004, 7'h02, 32'h0000_0004, 4'd2}, // R2
        '{12'h400, 12'hC00, 1'b0, 1'b0, 4'hE, 3'd0, 3'd4, 32'h5FFF_FFFC, 7'h08, 32'h07FF_FFFC, 4'd3}, // R3
        '{12'h400, 12'hC00, 1'b0, 1'b0, 4'hE, 3'd0, 3'd4, 32'h6000_0000, 7'h00, 32'h0000_0000, 4'd3}, // R3
        '{12'h400, 12'hC00, 1'b0, 1'b0, 4'hE, 3'd0, 3'd5, 32'h6000_0100, 7'h10, 32'h0000_0100, 4'd3}, // R3
        '{12'h400, 12'hC00, 1'b0, 1'b0, 4'h0, 3'd0, 3'd2, 32'h4000_2004, 7'h02, 32'h0000_0004, 4'd6}, // R6
        '{12'h400, 12'hC00, 1'b0, 1'b0, 4'h0, 3'd0, 3'd2, 32'h4000_4000, 7'h00, 32'h0000_0000, 4'd6}, // R6
        '{12'h400, 12'hC00, 1'b1, 1'b0, 4'hE, 3'd5, 3'd4, 32'h6000_0008, 7'h20, 32'h0000_0008, 4'd4}, // R4
        '{12'h400, 12'hC00, 1'b1, 1'b0, 4'hE, 3'd5, 3'd5, 32'h6800_0000, 7'h40, 32'h0000_0000, 4'd4}, // R4
        '{12'h400, 12'hC00, 1'b1, 1'b0, 4'hE, 3'd5, 3'd4, 32'h7000_0000, 7'h00, 32'h0000_0000, 4'd4}, // R4
        '{12'h400, 12'hC00, 1'b1, 1'b1, 4'hE, 3'd5, 3'd4, 32'h4000_0000, 7'h20, 32'h0000_0000, 4'd5}, // R5
        '{12'h400, 12'hC00, 1'b1, 1'b1, 4'hE, 3'd5, 3'd4, 32'h4800_0010, 7'h40, 32'h0000_0010, 4'd5}, // R5
        '{12'h400, 12'hC00, 1'b1, 1'b1, 4'hE, 3'd5, 3'd5, 32'h6000_0000, 7'h00, 32'h0000_0000, 4'd5}, // R5
        '{12'h400, 12'hC00, 1'b0, 1'b1, 4'hE, 3'd5, 3'd4, 32'h4000_0010, 7'h01, 32'h0000_0010, 4'd3}, // R3
        '{12'h400, 12'hC00, 1'b0, 1'b0, 4'hE, 3'd0, 3'd4, 32'h8000_0000, 7'h00, 32'h0000_0000, 4'd1}, // R1
        '{12'h400, 12'hC00, 1'b0, 1'b0, 4'hE, 3'd0, 3'd4, 32'h3FFF_FFFF, 7'h00, 32'h0000_0000, 4'd1}, // R1
        '{12'h400, 12'hC00, 1'b1, 1'b0, 4'hF, 3'd5, 3'd4, 32'h6000_0000, 7'h04, 32'h0000_0000, 4'd7}, // R7
        '{12'h000, 12'hF00, 1'b0, 1'b0, 4'hC, 3'd0, 3'd5, 32'h0A00_0000, 7'h10, 32'h0200_0000, 4'd1}, // R1
        '{12'h000, 12'hF00, 1'b0, 1'b0, 4'hC, 3'd0, 3'd5, 32'h0600_0004, 7'h08, 32'h0000_0004, 4'd2}, // R2
        '{12'h800, 12'h800, 1'b1, 1'b0, 4'hE, 3'd7, 3'd4, 32'hE000_0004, 7'h40, 32'h0000_0004, 4'd4}, // R4
        '{12'h400, 12'hC00, 1'b0, 1'b0, 4'hE, 3'd0, 3'd7, 32'h6000_0000, 7'h10, 32'h0000_0000, 4'd6}  // R6
    };

    // Compare all four outputs against expected values; expected hit and type follow R8.
    task automatic check_out(input int req, input string what,
                             input logic [6:0] exp_sel, input logic [31:0] exp_loc);
        logic exp_hit;
        logic exp_sd;
        exp_hit = (exp_sel != 7'h00);
        exp_sd  = (exp_sel[6:5] != 2'b00);
        checks++;
        if (bank_sel !== exp_sel || hit !== exp_hit || is_sdram !== exp_sd || local_addr !== exp_loc) begin
            errors++;
            $display("FAIL R%0d %s: sel=%h hit=%b sd=%b loc=%h expected sel=%h hit=%b sd=%b loc=%h",
                     req, what, bank_sel, hit, is_sdram, local_addr, exp_sel, exp_hit, exp_sd, exp_loc);
        end
    endtask

    task automatic apply(input vec_t v);
        win_base        = v.base;
        win_mask        = v.mask;
        sdram_en        = v.se;
        sram_dis        = v.si;
        sram_size_code  = v.ssz;
        sdram_size_code = v.dsz;
        sram_count      = v.cnt;
        bus_addr        = v.addr;
    endtask

    initial begin
        // R9: outputs are zero while reset is held
        repeat (2) @(negedge clk);
        check_out(9, "reset state", 7'h00, 32'h0);
        rst_n = 1'b1;

        // Table walk: drive at a falling edge, sample at the next falling edge.
        for (int n = 0; n < NV; n++) begin
            apply(VECS[n]);
            @(negedge clk);
            check_out(int'(VECS[n].req), $sformatf("vector %0d", n), VECS[n].sel, VECS[n].loc);
        end

        // R9: output holds until the capturing edge, then changes
        apply(VECS[0]);
        @(negedge clk);
        bus_addr = 32'h4800_0004;
        #2;
        check_out(9, "before edge", 7'h01, 32'h0000_0010);
        @(negedge clk);
        check_out(9, "after edge", 7'h02, 32'h0000_0004);

        // R9: reset in mid-run clears a live hit
        rst_n = 1'b0;
        @(negedge clk);
        check_out(9, "mid-run reset", 7'h00, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_out(9, "after release", 7'h02, 32'h0000_0004);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule